// File: doc/BRIEF.md
# Forty-source IRQ/FIQ interrupt controller

This block gathers forty level-sensitive interrupt lines and presents them to a processor as two request outputs: a normal request (IRQ) and a fast request (FIQ). Sources 0 to 31 occupy the low bank and sources 32 to 39 occupy bit positions 0 to 7 of the high bank. Each source has a mask (enable) bit and a route bit. A source that is pending and enabled drives FIQ when its route bit is 1 and IRQ when its route bit is 0.

When the core reports that it is halted, the block raises a wake request if any source is pending and either enabled or let through by an idle mask. The idle mask is all ones or all zeros. With the mask at all ones, a masked source can still wake the core without asserting IRQ or FIQ. Software controls the block through a 32-bit read/write port with byte offsets. It can read raw pending bits and the IRQ and FIQ views of the masked pending bits, and it can read and write the mask, route and idle-control registers.

All three outputs are registered. They change at the same clock edge that samples the input levels, the halt flag and any register write, so each output follows its cause by one clock.

Top module: `irq_fiq_ctrl`

## Requirements
- R1: Source i (i < 32) is bit i of the low bank, and source 32+k is bit k of the high bank. Raw pending reads at offset 0x10 (low bank) and 0xAC (high bank).
- R2: Each raw pending bit equals its input level as sampled at the most recent rising clock edge. A high pulse is not latched, and the bit clears once the input is sampled low.
- R3: irq_o is high exactly when some bank has a bit with pending=1, mask=1 and route=0. fiq_o is high exactly when some bank has a bit with pending=1, mask=1 and route=1. Both update at the clock edge that samples the inputs and registers they depend on.
- R4: Mask registers (0x04 low, 0xA0 high) and route registers (0x08 low, 0xA4 high) read back the last full 32-bit value written. This includes high-bank bits 8 to 31, which have no source.
- R5: The IRQ view (0x00 low, 0x9C high) reads pending & mask & ~route. The FIQ view (0x0C low, 0xA8 high) reads pending & mask & route.
- R6: Idle control at 0x14: writing 1 in bit 0 sets the idle mask to all zeros, and writing 0 in bit 0 sets it to all ones. A read returns 1 in bit 0 when the idle mask is zero and 0 otherwise, with bits 31 to 1 always zero.
- R7: wake_o is high after an edge exactly when core_halted was high at that edge and pending & (mask | idle mask) was nonzero in some bank. It is low whenever core_halted was sampled low.
- R8: Reset clears pending, mask and route in both banks, sets the idle mask to all zeros (0x14 reads 1), and drives irq_o, fiq_o and wake_o low.
- R9: Reads of any offset other than the eleven listed above return zero. This includes offsets that are not word-aligned. Writes to those offsets, and writes to the view and raw pending offsets, change no state.
- R10: High-bank pending bits 8 to 31 always read zero, both in the raw pending register and in the views.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| src_lvl | input | NUM_SRC (40) | Interrupt input levels, one per source |
| core_halted | input | 1 | High while the core is halted |
| wr_en | input | 1 | Register write strobe for the current cycle |
| addr | input | AW (8) | Byte offset of the register being accessed |
| wdata | input | DW (32) | Write data |
| rdata | output | DW (32) | Read data for addr; combinational from registered state |
| irq_o | output | 1 | Normal interrupt request |
| fiq_o | output | 1 | Fast interrupt request |
| wake_o | output | 1 | Wake request for a halted core |

## Verification
The checker tests the following on every cycle:
- irq_o and fiq_o agree with the OR of the IRQ and FIQ read views.
- Raw pending reads equal the input levels sampled one edge earlier, in both banks.
- Mask writes appear at the next edge.
- Undefined offsets read zero.
- wake_o stays low after an edge where the core was running.
- All outputs are low just after reset.

Some behaviour needs a sequence of accesses, so only the bench scenarios can show it:
- Route bits move a source between IRQ and FIQ.
- The idle mask lets a masked source wake the core without raising IRQ.
- Writes to read-only and undefined offsets leave the mask and route unchanged.
- The wake request tracks the halt flag.

// File: rtl/ifc_pkg.sv
package ifc_pkg;

   localparam int unsigned WORD_W = 32;
   localparam int unsigned MAX_BANKS = 2;

   // Register kinds decoded from the byte offset
   typedef enum logic [2:0] {
      K_NONE  = 3'd0,
      K_IRQV  = 3'd1,
      K_MASK  = 3'd2,
      K_ROUTE = 3'd3,
      K_FIQV  = 3'd4,
      K_RAW   = 3'd5,
      K_IDLE  = 3'd6
   } reg_kind_e;

   localparam logic [7:0] OFS_IDLE  = 8'h14;
   localparam logic [7:0] REL_IRQV  = 8'h00;
   localparam logic [7:0] REL_MASK  = 8'h04;
   localparam logic [7:0] REL_ROUTE = 8'h08;
   localparam logic [7:0] REL_FIQV  = 8'h0C;
   localparam logic [7:0] REL_RAW   = 8'h10;

   // Base offset of each bank's register group
   function automatic logic [7:0] bank_base(input int b);
      return (b == 0) ? 8'h00 : 8'h9C;
   endfunction

endpackage

// File: rtl/ifc_decode.sv
module ifc_decode
   import ifc_pkg::*;
#(
   parameter int unsigned NBANK = 2,
   parameter int unsigned AW    = 8
) (
   input  logic [AW-1:0]    addr,
   output logic [NBANK-1:0] bank_hit,
   output reg_kind_e        kind
);

   logic       upper_ok;
   logic [7:0] a8;

   assign a8 = addr[7:0];

   generate
      if (AW > 8) begin : g_hi
         assign upper_ok = ~|addr[AW-1:8];
      end else begin : g_nohi
         assign upper_ok = 1'b1;
      end
   endgenerate

   always_comb begin
      bank_hit = '0;
      kind     = K_NONE;
      if (upper_ok && (a8[1:0] == 2'b00)) begin
         if (a8 == OFS_IDLE) begin
            kind = K_IDLE;
         end
         for (int b = 0; b < NBANK; b++) begin
            if ((a8 >= bank_base(b)) && (a8 <= (bank_base(b) + REL_RAW))) begin
               bank_hit[b] = 1'b1;
               unique case (a8 - bank_base(b))
                  REL_IRQV:  kind = K_IRQV;
                  REL_MASK:  kind = K_MASK;
                  REL_ROUTE: kind = K_ROUTE;
                  REL_FIQV:  kind = K_FIQV;
                  REL_RAW:   kind = K_RAW;
                  default:   kind = K_NONE;
               endcase
            end
         end
      end
   end

endmodule

// File: rtl/ifc_bank.sv
module ifc_bank #(
   parameter int unsigned LIVE_W = 32,
   parameter int unsigned DW     = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [LIVE_W-1:0] src_lvl,
   input  logic              wr_mask,
   input  logic              wr_route,
   input  logic [DW-1:0]     wdata,
   input  logic              idle_all_d,
   output logic              irq_hit_d,
   output logic              fiq_hit_d,
   output logic              wake_hit_d,
   output logic [DW-1:0]     pend_q,
   output logic [DW-1:0]     mask_q,
   output logic [DW-1:0]     route_q,
   output logic [DW-1:0]     irq_view,
   output logic [DW-1:0]     fiq_view
);

   logic [DW-1:0] pend_d;
   logic [DW-1:0] mask_d;
   logic [DW-1:0] route_d;
   logic [DW-1:0] en_d;

   // Bits with no source always read as not pending
   generate
      if (LIVE_W < DW) begin : g_pad
         assign pend_d = {{(DW-LIVE_W){1'b0}}, src_lvl};
      end else begin : g_full
         assign pend_d = src_lvl;
      end
   endgenerate

   assign mask_d  = wr_mask  ? wdata : mask_q;
   assign route_d = wr_route ? wdata : route_q;
   assign en_d    = pend_d & mask_d;

   // Next-state request terms, so outputs register at the same edge as state
   assign irq_hit_d  = |(en_d & ~route_d);
   assign fiq_hit_d  = |(en_d & route_d);
   assign wake_hit_d = |(pend_d & (mask_d | {DW{idle_all_d}}));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q  <= '0;
         mask_q  <= '0;
         route_q <= '0;
      end else begin
         pend_q  <= pend_d;
         mask_q  <= mask_d;
         route_q <= route_d;
      end
   end

   assign irq_view = pend_q & mask_q & ~route_q;
   assign fiq_view = pend_q & mask_q & route_q;

endmodule

// File: rtl/ifc_outreg.sv
module ifc_outreg #(
   parameter int unsigned NBANK = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [NBANK-1:0] irq_hit,
   input  logic [NBANK-1:0] fiq_hit,
   input  logic [NBANK-1:0] wake_hit,
   input  logic             core_halted,
   output logic             irq_o,
   output logic             fiq_o,
   output logic             wake_o
);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irq_o  <= 1'b0;
         fiq_o  <= 1'b0;
         wake_o <= 1'b0;
      end else begin
         irq_o  <= |irq_hit;
         fiq_o  <= |fiq_hit;
         wake_o <= core_halted & (|wake_hit);
      end
   end

endmodule

// File: rtl/irq_fiq_ctrl.sv
module irq_fiq_ctrl
   import ifc_pkg::*;
#(
   parameter int unsigned NUM_SRC = 40,
   parameter int unsigned AW      = 8,
   parameter int unsigned DW      = 32
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [NUM_SRC-1:0] src_lvl,
   input  logic               core_halted,
   input  logic               wr_en,
   input  logic [AW-1:0]      addr,
   input  logic [DW-1:0]      wdata,
   output logic [DW-1:0]      rdata,
   output logic               irq_o,
   output logic               fiq_o,
   output logic               wake_o
);

   localparam int unsigned NBANK = (NUM_SRC + DW - 1) / DW;
   localparam int unsigned ALL_W = NBANK * DW;

   // Elaboration checks on the parameter set
   generate
      if (DW != WORD_W) begin : g_bad_dw
         $error("irq_fiq_ctrl: DW must equal the 32-bit register width");
      end
      if ((NUM_SRC <= DW) || (NBANK > MAX_BANKS)) begin : g_bad_src
         $error("irq_fiq_ctrl: NUM_SRC must lie in 33..64");
      end
      if (AW < 8) begin : g_bad_aw
         $error("irq_fiq_ctrl: AW must be at least 8");
      end
   endgenerate

   logic [NBANK-1:0] bank_hit;
   reg_kind_e        kind;
   logic             idle_all_q;
   logic             idle_all_d;
   logic             idle_wr;

   logic [ALL_W-1:0] pend_all;
   logic [ALL_W-1:0] mask_all;
   logic [ALL_W-1:0] route_all;
   logic [ALL_W-1:0] irq_view_all;
   logic [ALL_W-1:0] fiq_view_all;
   logic [NBANK-1:0] irq_hit;
   logic [NBANK-1:0] fiq_hit;
   logic [NBANK-1:0] wake_hit;

   ifc_decode #(.NBANK(NBANK), .AW(AW)) u_dec (
      .addr     (addr),
      .bank_hit (bank_hit),
      .kind     (kind)
   );

   // Idle mask kept as one bit: 1 means all ones
   assign idle_wr    = wr_en && (kind == K_IDLE);
   assign idle_all_d = idle_wr ? ~wdata[0] : idle_all_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         idle_all_q <= 1'b0;
      end else begin
         idle_all_q <= idle_all_d;
      end
   end

   generate
      for (genvar b = 0; b < NBANK; b++) begin : g_bank
         localparam int unsigned LEFT = NUM_SRC - b * DW;
         localparam int unsigned LIVE = (LEFT > DW) ? DW : LEFT;
         logic wr_m;
         logic wr_r;

         assign wr_m = wr_en && bank_hit[b] && (kind == K_MASK);
         assign wr_r = wr_en && bank_hit[b] && (kind == K_ROUTE);

         ifc_bank #(.LIVE_W(LIVE), .DW(DW)) u_bank (
            .clk        (clk),
            .rst_n      (rst_n),
            .src_lvl    (src_lvl[b*DW +: LIVE]),
            .wr_mask    (wr_m),
            .wr_route   (wr_r),
            .wdata      (wdata),
            .idle_all_d (idle_all_d),
            .irq_hit_d  (irq_hit[b]),
            .fiq_hit_d  (fiq_hit[b]),
            .wake_hit_d (wake_hit[b]),
            .pend_q     (pend_all[b*DW +: DW]),
            .mask_q     (mask_all[b*DW +: DW]),
            .route_q    (route_all[b*DW +: DW]),
            .irq_view   (irq_view_all[b*DW +: DW]),
            .fiq_view   (fiq_view_all[b*DW +: DW])
         );
      end
   endgenerate

   ifc_outreg #(.NBANK(NBANK)) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .irq_hit     (irq_hit),
      .fiq_hit     (fiq_hit),
      .wake_hit    (wake_hit),
      .core_halted (core_halted),
      .irq_o       (irq_o),
      .fiq_o       (fiq_o),
      .wake_o      (wake_o)
   );

   // Read mux; undefined offsets fall through to zero
   always_comb begin
      rdata = '0;
      if (kind == K_IDLE) begin
         rdata = {{(DW-1){1'b0}}, ~idle_all_q};
      end
      for (int b = 0; b < NBANK; b++) begin
         if (bank_hit[b]) begin
            unique case (kind)
               K_IRQV:  rdata = irq_view_all[b*DW +: DW];
               K_MASK:  rdata = mask_all[b*DW +: DW];
               K_ROUTE: rdata = route_all[b*DW +: DW];
               K_FIQV:  rdata = fiq_view_all[b*DW +: DW];
               K_RAW:   rdata = pend_all[b*DW +: DW];
               default: rdata = '0;
            endcase
         end
      end
   end

endmodule

// File: rtl/ifc_checker.sv
module ifc_checker #(
   parameter int unsigned NUM_SRC = 40,
   parameter int unsigned AW      = 8,
   parameter int unsigned DW      = 32
) (
   input logic                               clk,
   input logic                               rst_n,
   input logic [NUM_SRC-1:0]                 src_lvl,
   input logic                               core_halted,
   input logic                               wr_en,
   input logic [AW-1:0]                      addr,
   input logic [DW-1:0]                      wdata,
   input logic [DW-1:0]                      rdata,
   input logic                               irq_o,
   input logic                               fiq_o,
   input logic                               wake_o,
   input logic [((NUM_SRC+DW-1)/DW)*DW-1:0]  mask_all,
   input logic [((NUM_SRC+DW-1)/DW)*DW-1:0]  irq_view_all,
   input logic [((NUM_SRC+DW-1)/DW)*DW-1:0]  fiq_view_all
);

   localparam int unsigned HI_W = NUM_SRC - DW;

   logic past_ok;
   logic defined;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) past_ok <= 1'b0;
      else        past_ok <= 1'b1;
   end

   always_comb begin
      defined = 1'b0;
      if (addr == AW'('h00) || addr == AW'('h04) || addr == AW'('h08) ||
          addr == AW'('h0C) || addr == AW'('h10) || addr == AW'('h14) ||
          addr == AW'('h9C) || addr == AW'('hA0) || addr == AW'('hA4) ||
          addr == AW'('hA8) || addr == AW'('hAC))
         defined = 1'b1;
   end

   // R3
   p_irq_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (irq_o == (|irq_view_all)));

   // R3
   p_fiq_view_r3: assert property (@(posedge clk) disable iff (!rst_n)
      past_ok |-> (fiq_o == (|fiq_view_all)));

   // R2
   p_low_follow_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && addr == AW'('h10)) |-> (rdata == $past(src_lvl[DW-1:0])));

   // R1
   p_high_follow_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && addr == AW'('hAC)) |-> (rdata[HI_W-1:0] == $past(src_lvl[NUM_SRC-1:DW])));

   // R10
   p_high_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'('hAC)) |-> (rdata[DW-1:HI_W] == '0));

   // R4
   p_mask_low_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'('h04)) |=> (mask_all[DW-1:0] == $past(wdata)));

   // R4
   p_mask_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && addr == AW'('hA0)) |=> (mask_all[2*DW-1:DW] == $past(wdata)));

   // R6
   p_idle_read_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (addr == AW'('h14)) |-> (rdata[DW-1:1] == '0));

   // R7
   p_wake_run_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (past_ok && !$past(core_halted)) |-> !wake_o);

   // R9
   p_undef_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
      !defined |-> (rdata == '0));

   // R8
   p_reset_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rst_n) |-> (!irq_o && !fiq_o && !wake_o));

endmodule

bind irq_fiq_ctrl ifc_checker #(.NUM_SRC(NUM_SRC), .AW(AW), .DW(DW)) u_chk (.*);

// File: tb/sim_irq_fiq_ctrl.sv
`timescale 1ns/1ps
module sim_irq_fiq_ctrl;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [39:0] src_lvl = '0;
   logic        core_halted = 1'b0;
   logic        wr_en = 1'b0;
   logic [7:0]  addr = '0;
   logic [31:0] wdata = '0;
   logic [31:0] rdata;
   logic        irq_o, fiq_o, wake_o;

   int nchk = 0;
   int nerr = 0;
   bit done = 1'b0;

   // Bench model
   logic [31:0] m_mask [2];
   logic [31:0] m_route[2];
   bit          m_idle_all;
   logic [39:0] m_src;
   bit          m_halt;

   always #5 clk = ~clk;

   irq_fiq_ctrl u0 (
      .clk(clk), .rst_n(rst_n), .src_lvl(src_lvl), .core_halted(core_halted),
      .wr_en(wr_en), .addr(addr), .wdata(wdata), .rdata(rdata),
      .irq_o(irq_o), .fiq_o(fiq_o), .wake_o(wake_o)
   );

   function automatic logic [31:0] m_pend(input int b);
      return (b == 0) ? m_src[31:0] : {24'h0, m_src[39:32]};
   endfunction

   function automatic logic [31:0] exp_read(input logic [7:0] a);
      case (a)
         8'h00: return m_pend(0) & m_mask[0] & ~m_route[0];
         8'h04: return m_mask[0];
         8'h08: return m_route[0];
         8'h0C: return m_pend(0) & m_mask[0] & m_route[0];
         8'h10: return m_pend(0);
         8'h14: return {31'h0, ~m_idle_all};
         8'h9C: return m_pend(1) & m_mask[1] & ~m_route[1];
         8'hA0: return m_mask[1];
         8'hA4: return m_route[1];
         8'hA8: return m_pend(1) & m_mask[1] & m_route[1];
         8'hAC: return m_pend(1);
         default: return 32'h0;
      endcase
   endfunction

   function automatic bit exp_irq();
      return |(m_pend(0) & m_mask[0] & ~m_route[0]) || |(m_pend(1) & m_mask[1] & ~m_route[1]);
   endfunction

   function automatic bit exp_fiq();
      return |(m_pend(0) & m_mask[0] & m_route[0]) || |(m_pend(1) & m_mask[1] & m_route[1]);
   endfunction

   function automatic bit exp_wake();
      logic [31:0] im;
      im = {32{m_idle_all}};
      return m_halt && (|(m_pend(0) & (m_mask[0] | im)) || |(m_pend(1) & (m_mask[1] | im)));
   endfunction

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      nchk++;
      if (act !== exp) begin
         nerr++;
         $display("FAIL %s act=%h exp=%h", tag, act, exp);
      end
   endtask

   // Drive one cycle of stimulus; model follows the capturing edge
   task automatic step(input logic [39:0] s, input bit h, input bit w,
                       input logic [7:0] a, input logic [31:0] d);
      @(negedge clk);
      src_lvl = s; core_halted = h; wr_en = w; addr = a; wdata = d;
      @(posedge clk);
      #1;
      wr_en = 1'b0;
      m_src = s; m_halt = h;
      if (w) begin
         case (a)
            8'h04: m_mask[0] = d;
            8'h08: m_route[0] = d;
            8'hA0: m_mask[1] = d;
            8'hA4: m_route[1] = d;
            8'h14: m_idle_all = ~d[0];
            default: ;
         endcase
      end
   endtask

   task automatic rd(input string tag, input logic [7:0] a);
      addr = a;
      #1;
      chk(tag, rdata, exp_read(a));
   endtask

   task automatic outs(input string tag);
      chk({tag, " irq_o"},  {31'h0, irq_o},  {31'h0, exp_irq()});
      chk({tag, " fiq_o"},  {31'h0, fiq_o},  {31'h0, exp_fiq()});
      chk({tag, " wake_o"}, {31'h0, wake_o}, {31'h0, exp_wake()});
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         nerr++;
         $display("FAIL watchdog expired");
         $display("Result: errors=%0d of %0d checks", nerr, nchk);
         $finish;
      end
   end

   initial begin
      logic [7:0] alist [16];
      alist = '{8'h00, 8'h04, 8'h08, 8'h0C, 8'h10, 8'h14, 8'h9C, 8'hA0,
                8'hA4, 8'hA8, 8'hAC, 8'h18, 8'h1C, 8'h98, 8'hB0, 8'h06};
      void'($urandom(32'd20240611));
      m_mask = '{32'h0, 32'h0}; m_route = '{32'h0, 32'h0};
      m_idle_all = 1'b0; m_src = '0; m_halt = 1'b0;

      // R8: reset state
      repeat (3) @(posedge clk);
      #1;
      outs("R8 in reset");
      rd("R8 mask0 reset", 8'h04);
      rd("R8 idle reset", 8'h14);
      @(negedge clk); rst_n = 1'b1;
      step('0, 1'b0, 1'b0, 8'h00, 32'h0);
      outs("R8 after reset");
      rd("R8 route1 reset", 8'hA4);
      rd("R8 raw0 reset", 8'h10);

      // R1 and R2: bank mapping and level following
      step(40'h00_0000_0020, 1'b0, 1'b0, 8'h00, 32'h0);
      rd("R1 low bank bit5", 8'h10);
      step(40'h08_0000_0000, 1'b0, 1'b0, 8'h00, 32'h0);
      rd("R1 high bank src35", 8'hAC);
      rd("R2 low cleared", 8'h10);
      step(40'h0, 1'b0, 1'b0, 8'h00, 32'h0);
      rd("R2 high cleared", 8'hAC);

      // R4: full-width readback
      step(40'h0, 1'b0, 1'b1, 8'h04, 32'hFFFF_FFFF);
      step(40'h0, 1'b0, 1'b1, 8'hA0, 32'hFFFF_FF00);
      step(40'h0, 1'b0, 1'b1, 8'hA4, 32'hA5A5_0000);
      rd("R4 mask0", 8'h04);
      rd("R4 mask1 upper", 8'hA0);
      rd("R4 route1 upper", 8'hA4);

      // R3 and R5: routing of a low-bank source
      step(40'h00_0000_0008, 1'b0, 1'b0, 8'h00, 32'h0);
      outs("R3 src3 to irq");
      rd("R5 irq view", 8'h00);
      step(40'h00_0000_0008, 1'b0, 1'b1, 8'h08, 32'h0000_0008);
      outs("R3 src3 to fiq");
      rd("R5 fiq view", 8'h0C);
      rd("R5 irq view empty", 8'h00);
      // high-bank source 36 (bit 4): mask1 bit4 is zero, enable it
      step(40'h10_0000_0000, 1'b0, 1'b1, 8'hA0, 32'hFFFF_FF10);
      outs("R3 src36 irq");
      step(40'h10_0000_0000, 1'b0, 1'b1, 8'hA4, 32'h0000_0010);
      outs("R3 src36 fiq");
      rd("R5 high fiq view", 8'hA8);
      rd("R10 high raw", 8'hAC);

      // R6: idle control
      step(40'h0, 1'b0, 1'b1, 8'h14, 32'h0);
      rd("R6 idle ones", 8'h14);
      step(40'h0, 1'b0, 1'b1, 8'h14, 32'hFFFF_FFFF);
      rd("R6 idle zeros", 8'h14);

      // R7: wake on masked source only with idle mask set
      step(40'h0, 1'b0, 1'b1, 8'h04, 32'h0);
      step(40'h00_0000_0100, 1'b1, 1'b0, 8'h00, 32'h0);
      outs("R7 masked no wake");
      step(40'h00_0000_0100, 1'b1, 1'b1, 8'h14, 32'h0);
      outs("R7 idle wake");
      step(40'h00_0000_0100, 1'b0, 1'b0, 8'h00, 32'h0);
      outs("R7 running no wake");

      // R9: writes to read-only and undefined offsets
      step(40'h0, 1'b0, 1'b1, 8'h00, 32'hFFFF_FFFF);
      step(40'h0, 1'b0, 1'b1, 8'h10, 32'hFFFF_FFFF);
      step(40'h0, 1'b0, 1'b1, 8'h18, 32'hFFFF_FFFF);
      step(40'h0, 1'b0, 1'b1, 8'h05, 32'hFFFF_FFFF);
      rd("R9 mask0 kept", 8'h04);
      rd("R9 route0 kept", 8'h08);
      rd("R9 undef read", 8'h18);
      rd("R9 unaligned read", 8'h02);

      // Random mix
      for (int i = 0; i < 500; i++) begin
         logic [39:0] s;
         logic [7:0]  a;
         s = {$urandom(), $urandom()} & {$urandom(), $urandom()};
         a = alist[$urandom_range(0, 15)];
         step(s, 1'($urandom()), 1'($urandom()), a, $urandom());
         outs("R3 R7 random");
         rd("R5 R9 random read", alist[$urandom_range(0, 15)]);
         rd("R1 R10 random raw", 8'hAC);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
   end

endmodule